// File: doc/BRIEF.md
# Vector Floating-Point Magnitude Max/Min Unit

This block is a lane-parallel arithmetic unit. It takes two packed floating-point vectors and, in each lane, returns whichever operand has the larger (or the smaller) absolute value. The sign of both operands is discarded before the comparison, so a non-NaN result is always non-negative. Lanes hold 16-bit, 32-bit or 64-bit IEEE 754 values. The vector is either 128 bits wide or 64 bits wide; in the 64-bit case the upper half of the result is zero.

The unit decodes the operation, element size and vector length from a 32-bit instruction word. It also takes a feature-enable input. An illegal or disabled instruction is reported as undefined. The unit takes the current floating-point status flags and returns them merged with what the operation raised. Flush-to-zero plays no part here, so subnormal values pass through bit-exactly. The input-denormal flag is passed through unchanged and is never set.

One vector is accepted per cycle. Its result, flags and undefined indication appear on the outputs one clock later.

Top module: `vec_famm_unit`

## Requirements
- R1: The half-precision form is recognised when insn[31]=0, insn[28:24]=01110, insn[23:21]=110 and insn[15:10]=000111. insn[29]=0 selects magnitude max and insn[29]=1 selects magnitude min. insn[30]=1 selects a 128-bit vector and insn[30]=0 selects a 64-bit vector. Lane l occupies bits [16l+15:16l].
- R2: The single/double form is recognised when insn[31]=0, insn[28:24]=01110, insn[23]=1, insn[21]=1 and insn[15:10]=110111. insn[22]=0 selects 32-bit lanes and insn[22]=1 selects 64-bit lanes, laid out the same way as in R1. Bits 29 and 30 have the meaning given in R1.
- R3: When feat_en is 0, every instruction raises undef. The result is then zero and flags_out equals flags_in.
- R4: Each of the following raises undef, with a zero result and unchanged flags: an encoding that matches neither form, and 64-bit lanes with a 64-bit vector (insn[22]=1, insn[30]=0).
- R5: When neither lane operand is a NaN, the lane result is the larger magnitude (max) or the smaller magnitude (min), with the sign bit cleared.
- R6: Zeros of either sign compare equal, and such a lane returns +0.
- R7: When either lane operand is a NaN, the lane returns the positive default quiet NaN. This is 0x7E00, 0x7FC00000 or 0x7FF8000000000000, depending on the lane width.
- R8: A signalling NaN in a live lane sets flags_out[0] (invalid operation). A quiet NaN does not set it.
- R9: flags_out is flags_in ORed with the flags raised by the operation. Bit 5 (input denormal) always equals flags_in[5]. Subnormal operands are compared and returned bit-exactly.
- R10: With a 64-bit vector, result[127:64] is zero and the upper lanes raise no flag.
- R11: out_valid equals in_valid delayed by one clock. result, flags_out and undef belong to the input of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and instruction are present this cycle |
| insn | input | 32 | Instruction word to decode |
| feat_en | input | 1 | Feature implemented; 0 makes every instruction undefined |
| src_a | input | 128 | First packed operand vector |
| src_b | input | 128 | Second packed operand vector |
| flags_in | input | 6 | Current status flags (bit 0 invalid, bit 5 input denormal) |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 128 | Packed lane results |
| flags_out | output | 6 | Merged status flags |
| undef | output | 1 | Instruction was undefined |

## Verification
The bench targets the following corner cases, and each one exposes a specific mistake:
- **Signed zeros.** A design that compared signed values would return -0, or a negative operand.
- **Subnormal pairs.** A design that flushed subnormals would return zero where a tiny magnitude is expected.
- **Input-denormal flag.** The bench drives the incoming bit 5 both set and clear. A design that set or cleared it would show up as a flag mismatch.
- **Quiet and signalling NaNs.** Only signalling NaNs may raise invalid operation. A design that propagated the operand's payload, or flagged quiet NaNs, would fail here.
- **64-bit vectors with signalling NaNs in the upper lanes.** A design that leaked those lanes into the result or the flags would fail here.
- **Reserved and malformed encodings, and a disabled feature.** A design that accepted any of these would produce data instead of undef.

// File: rtl/famm_pkg.sv
package famm_pkg;
    localparam int VEC_W   = 128;
    localparam int INSN_W  = 32;
    localparam int FLAG_W  = 6;
    localparam int FLG_INV = 0;
    localparam int FLG_IDN = 5;
    localparam int N_FMT   = 3;

    typedef enum logic [1:0] {
        ESZ_H = 2'd0,
        ESZ_S = 2'd1,
        ESZ_D = 2'd2
    } esz_e;

    typedef struct packed {
        logic legal;
        logic wide;
        logic is_min;
        esz_e esz;
    } dec_t;

    function automatic int exp_bits(input int w);
        return (w == 16) ? 5 : (w == 32) ? 8 : 11;
    endfunction
endpackage

// File: rtl/famm_decode.sv
module famm_decode
    import famm_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              feat_en,
    output dec_t              dec
);
    logic base_ok, half_form, sd_form, reserved;

    always_comb begin
        base_ok   = (insn[31] == 1'b0) && (insn[28:24] == 5'b01110);
        half_form = (insn[23:21] == 3'b110) && (insn[15:10] == 6'b000111);
        sd_form   = insn[23] && insn[21] && (insn[15:10] == 6'b110111);
        reserved  = sd_form && insn[22] && !insn[30];

        dec.legal  = feat_en && base_ok && (half_form || sd_form) && !reserved;
        dec.wide   = insn[30];
        dec.is_min = insn[29];
        dec.esz    = half_form ? ESZ_H : (insn[22] ? ESZ_D : ESZ_S);
    end
endmodule

// File: rtl/famm_lane.sv
module famm_lane #(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_min,
    output logic [W-1:0] y,
    output logic         snan
);
    localparam int MW = W - EW - 1;
    localparam logic [W-1:0] DFLT_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    logic [W-1:0] mag_a, mag_b;
    logic         nan_a, nan_b, a_bigger;

    always_comb begin
        mag_a    = {1'b0, a[W-2:0]};
        mag_b    = {1'b0, b[W-2:0]};
        nan_a    = (&a[W-2:MW]) && (|a[MW-1:0]);
        nan_b    = (&b[W-2:MW]) && (|b[MW-1:0]);
        snan     = (nan_a && !a[MW-1]) || (nan_b && !b[MW-1]);
        a_bigger = mag_a > mag_b;
        if (nan_a || nan_b)
            y = DFLT_NAN;
        else if (is_min)
            y = a_bigger ? mag_b : mag_a;
        else
            y = a_bigger ? mag_a : mag_b;
    end

    // R5: an ordered result is one of the magnitudes and bounds both
    always_comb begin
        if (!(nan_a || nan_b)) begin
            p_mag_order_r5: assert (is_min ? (y <= mag_a && y <= mag_b)
                                           : (y >= mag_a && y >= mag_b));
            p_nonneg_r5: assert (y[W-1] == 1'b0 && (y == mag_a || y == mag_b));
        end
    end
endmodule

// File: rtl/famm_datapath.sv
module famm_datapath
    import famm_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    input  dec_t          dec,
    output logic [VW-1:0] res,
    output logic          inv
);
    localparam int HALF = VW / 2;

    logic [VW-1:0]    fmt_res [N_FMT];
    logic [N_FMT-1:0] fmt_inv;

    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        localparam int W     = 16 << g;
        localparam int LANES = VW / W;
        logic [VW-1:0]    r_g;
        logic [LANES-1:0] sn_live;

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic sn;
            famm_lane #(.W(W), .EW(exp_bits(W))) lane_i (
                .a      (a[l*W +: W]),
                .b      (b[l*W +: W]),
                .is_min (dec.is_min),
                .y      (r_g[l*W +: W]),
                .snan   (sn)
            );
            if (l * W < HALF) begin : g_low
                assign sn_live[l] = sn;
            end else begin : g_high
                assign sn_live[l] = sn && dec.wide;
            end
        end

        assign fmt_res[g] = r_g;
        assign fmt_inv[g] = |sn_live;
    end

    always_comb begin
        res = fmt_res[dec.esz];
        inv = fmt_inv[dec.esz];
        if (!dec.wide)
            res[VW-1:HALF] = '0;
    end
endmodule

// File: rtl/vec_famm_unit.sv
module vec_famm_unit
    import famm_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic              feat_en,
    input  logic [VW-1:0]     src_a,
    input  logic [VW-1:0]     src_b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [VW-1:0]     result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              undef
);
    typedef struct packed {
        logic              vld;
        logic              und;
        logic              wide;
        logic [VW-1:0]     res;
        logic [FLAG_W-1:0] flg;
    } st_t;

    dec_t          dec;
    logic [VW-1:0] dp_res;
    logic          dp_inv;
    st_t           st_d, st_q;

    famm_decode dec_i (
        .insn    (insn),
        .feat_en (feat_en),
        .dec     (dec)
    );

    famm_datapath #(.VW(VW)) dp_i (
        .a   (src_a),
        .b   (src_b),
        .dec (dec),
        .res (dp_res),
        .inv (dp_inv)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.und  = !dec.legal;
        st_d.wide = dec.wide;
        st_d.res  = dec.legal ? dp_res : '0;
        st_d.flg  = flags_in;
        st_d.flg[FLG_INV] = flags_in[FLG_INV] | (dec.legal & dp_inv);
        st_d.flg[FLG_IDN] = flags_in[FLG_IDN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flags_out = st_q.flg;
    assign undef     = st_q.vld & st_q.und;

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_undef_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !feat_en |=> undef && result == '0 && flags_out == $past(flags_in));
    p_idn_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> flags_out[FLG_IDN] == $past(flags_in[FLG_IDN]));
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flags_out & $past(flags_in)) == $past(flags_in));
    p_narrow_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !insn[30] |=> result[VW-1:VW/2] == '0);
endmodule

// File: tb/vec_famm_unit_tb.sv
module vec_famm_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic         feat_en = 1'b1;
    logic [127:0] src_a = '0, src_b = '0;
    logic [5:0]   flags_in = '0;
    logic         out_valid, undef;
    logic [127:0] result;
    logic [5:0]   flags_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vec_famm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .feat_en(feat_en), .src_a(src_a), .src_b(src_b), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .flags_out(flags_out), .undef(undef)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_lane(input logic [63:0] a, input logic [63:0] b,
                                             input int w, input bit mn, output bit sn);
        int e = (w == 16) ? 5 : (w == 32) ? 8 : 11;
        int m = w - e - 1;
        logic [63:0] mask = (64'd1 << (w - 1)) - 64'd1;
        logic [63:0] inf  = ((64'd1 << e) - 64'd1) << m;
        logic [63:0] ma = a & mask, mb = b & mask;
        bit na = ma > inf, nb = mb > inf;
        sn = (na && !ma[m-1]) || (nb && !mb[m-1]);
        if (na || nb) return inf | (64'd1 << (m - 1));
        if (mn) return (ma < mb) ? ma : mb;
        return (ma > mb) ? ma : mb;
    endfunction

    function automatic logic [31:0] mk_insn(input bit q, input bit u, input int sz);
        logic [4:0] rm = 5'($urandom), rn = 5'($urandom), rd = 5'($urandom);
        if (sz == 0) return {1'b0, q, u, 5'b01110, 3'b110, rm, 6'b000111, rn, rd};
        return {1'b0, q, u, 5'b01110, 1'b1, sz == 2, 1'b1, rm, 6'b110111, rn, rd};
    endfunction

    // drive one vector, check the registered outputs one clock later
    task automatic run(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b,
                       input logic [5:0] fl, input bit fe, input string tag);
        bit half = ins[23:21] == 3'b110 && ins[15:10] == 6'b000111;
        bit sd   = ins[23] && ins[21] && ins[15:10] == 6'b110111;
        bit q = ins[30], u = ins[29];
        int w = half ? 16 : (ins[22] ? 64 : 32);
        bit ud = !fe || ins[31] || ins[28:24] != 5'b01110 || !(half || sd) ||
                 (sd && ins[22] && !q);
        logic [127:0] er = '0;
        logic [5:0]   ef = fl;
        if (!ud) begin
            int lanes = (q ? 128 : 64) / w;
            logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            for (int l = 0; l < lanes; l++) begin
                bit sn;
                logic [63:0] la = 64'(a >> (l * w)) & mask;
                logic [63:0] lb = 64'(b >> (l * w)) & mask;
                er |= 128'(ref_lane(la, lb, w, u, sn)) << (l * w);
                if (sn) ef[0] = 1'b1;
            end
        end
        @(negedge clk);
        insn = ins; src_a = a; src_b = b; flags_in = fl; feat_en = fe; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R11", {tag, " out_valid"}, 128'(out_valid), 128'd1);
        chk(undef == ud, ud ? "R3/R4" : tag, "undef", 128'(undef), 128'(ud));
        chk(result == er, tag, "result", result, er);
        chk(flags_out == ef, "R9", {tag, " flags"}, 128'(flags_out), 128'(ef));
    endtask

    function automatic logic [63:0] mk_val(input int w);
        int e = (w == 16) ? 5 : (w == 32) ? 8 : 11;
        int m = w - e - 1;
        logic [63:0] r = {$urandom, $urandom};
        logic [63:0] mm = (64'd1 << m) - 64'd1;
        logic [63:0] inf = ((64'd1 << e) - 64'd1) << m;
        logic [63:0] s = 64'(r[63]) << (w - 1);
        case ($urandom % 8)
            0: return s | inf | ((r & (mm >> 1)) | 64'd1);
            1: return s | inf | (64'd1 << (m - 1)) | (r & (mm >> 1));
            2: return s;
            3: return s | (r & mm);
            4: return s | inf;
            default: return r & ((w == 64) ? '1 : ((64'd1 << w) - 64'd1));
        endcase
    endfunction

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && result == '0 && flags_out == '0, "R11", "reset state",
            {out_valid, flags_out, result[120:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0, "R11", "idle no valid", 128'(out_valid), 0);

        // R6: signed zeros, half, max and min
        run(mk_insn(1, 0, 0), {8{16'h8000}}, {8{16'h0000}}, 6'h00, 1, "R6 zero max");
        run(mk_insn(1, 1, 0), {8{16'h8000}}, {8{16'h8000}}, 6'h00, 1, "R6 zero min");
        // R5: -5.0 vs 3.0 single
        run(mk_insn(1, 0, 1), {4{32'hC0A00000}}, {4{32'h40400000}}, 6'h00, 1, "R5 max");
        run(mk_insn(1, 1, 1), {4{32'hC0A00000}}, {4{32'h40400000}}, 6'h00, 1, "R5 min");
        // R9: subnormals, input-denormal bit kept set / kept clear
        run(mk_insn(1, 0, 1), {4{32'h80000001}}, {4{32'h00000003}}, 6'h20, 1, "R9 sub max");
        run(mk_insn(1, 1, 1), {4{32'h80000001}}, {4{32'h00000003}}, 6'h00, 1, "R9 sub min");
        run(mk_insn(1, 1, 2), {2{64'h800F000000000000}}, {2{64'h0000000000000002}},
            6'h1E, 1, "R9 sub dbl");
        // R7/R8: quiet NaN no invalid, signalling NaN invalid
        run(mk_insn(1, 0, 0), {8{16'hFE01}}, {8{16'h3C00}}, 6'h00, 1, "R7 qnan half");
        run(mk_insn(1, 1, 2), {2{64'h3FF0000000000000}}, {2{64'h7FF0000000000001}},
            6'h00, 1, "R8 snan dbl");
        // R10: 64-bit vector, signalling NaNs only in the upper lanes
        run(mk_insn(0, 0, 1), {{2{32'h7F800001}}, 32'h3F800000, 32'h80000000},
            {{2{32'h7F800001}}, 32'hBF000000, 32'h00000000}, 6'h00, 1, "R10 narrow");
        // R3/R4: disabled feature, reserved and malformed encodings
        run(mk_insn(1, 0, 1), '1, '1, 6'h21, 0, "R3 disabled");
        run(mk_insn(0, 0, 2), '1, '1, 6'h05, 1, "R4 reserved");
        run(mk_insn(1, 0, 0) ^ 32'h0000_0400, '1, '1, 6'h00, 1, "R4 malformed");
        run(mk_insn(1, 0, 1) | 32'h8000_0000, '1, '1, 6'h00, 1, "R4 bit31");

        // R1/R2: random lanes with special values mixed in
        for (int i = 0; i < 400; i++) begin
            int sz = $urandom % 3;
            bit q = (sz == 2) ? 1'b1 : 1'($urandom);
            int w = 16 << sz;
            logic [127:0] a = '0, b = '0;
            for (int l = 0; l < 128 / w; l++) begin
                a |= 128'(mk_val(w)) << (l * w);
                b |= 128'(mk_val(w)) << (l * w);
            end
            run(mk_insn(q, 1'($urandom), sz), a, b, 6'($urandom),
                1, sz == 0 ? "R1 rand" : "R2 rand");
        end

        @(negedge clk);
        chk(out_valid == 0, "R11", "drain", 128'(out_valid), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule